// File: doc/BRIEF.md
# Dual-Mode Indirect Control Register File

This block is the control store of a host-attached peripheral. The host reaches it through two byte-wide ports: an index port, which holds a pointer, and a data port, which reads or writes the indirect register that the pointer selects. The index port sits on the write path and the read path separately, so one cycle can write one port and read the other. Every register is exported as a flat control vector, so the datapaths of the peripheral can consume the settings directly.

After reset the block runs in a legacy-compatible mode, where only a base bank of 16 indirect registers answers. The host switches modes by writing one bit of a miscellaneous control register in the base bank. While that bit is set, an extended bank of 16 more registers answers at indices 16 to 31. Clearing the bit hides the extended bank again. The extended bank keeps its contents while it is hidden. One extended register carries a full-duplex DMA enable and separate power-down controls for the capture, playback and mixer paths. These controls take effect only in expanded mode. The playback and capture FIFO enables stay asserted in both modes.

A two-state machine tracks the mode. Its states are `MODE_LEGACY` (the reset state) and `MODE_EXPANDED`. The transition `ENTER_EXPANDED` happens on a data-port write of the miscellaneous register with the mode bit at 1. The transition `LEAVE_EXPANDED` happens on such a write with the mode bit at 0. A write of the miscellaneous register that does not change the mode bit keeps the current state.

Top module: `dual_mode_regfile`

## Requirements
- R1: After reset, `mode_exp` is 0, the index register reads 0, all registers in both banks are 0, and `host_rdata` is 0.
- R2: A write to the index port (`host_wr` with `host_wr_sel`=0) stores all 8 bits. A read of the index port returns them unchanged, and the index register changes only on such writes.
- R3: With a decoded index (index bits 4:0) of 0 to 15, a data-port write (`host_wr_sel`=1) stores the byte in that base register. A data-port read (`host_rd_sel`=1) returns it. No other base register changes.
- R4: A data-port write to base index 12 enters expanded mode when bit 6 of the byte is 1 and leaves it when bit 6 is 0. `mode_exp` shows the new mode from the clock edge that takes the write, and always equals bit 6 of register 12.
- R5: In legacy mode, data-port writes to decoded indices 16 to 31 leave the extended bank and `ext_regs_o` unchanged, and data-port reads from those indices return 0.
- R6: In expanded mode, decoded indices 16 to 31 write and read extended registers 0 to 15.
- R7: The contents of the extended bank are kept through any number of mode changes.
- R8: `fifo_play_en` and `fifo_cap_en` are 1 in both modes.
- R9: Extended register 0 (index 16) drives four controls. Bit 0 drives `duplex_dma_en`, bit 1 drives `pd_capture`, bit 2 drives `pd_playback` and bit 3 drives `pd_mixer`. In expanded mode each control follows its bit. In legacy mode all four are 0.
- R10: A data-port access uses the index held before the clock edge. An index write in the same cycle affects only later accesses. Index bits 7:5 do not take part in decoding.
- R11: `host_rdata` takes the read value at the clock edge that samples `host_rd`. It holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe, one access per asserted cycle |
| host_wr_sel | input | 1 | Write target: 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write byte |
| host_rd | input | 1 | Read strobe |
| host_rd_sel | input | 1 | Read source: 0 = index port, 1 = data port |
| host_rdata | output | 8 | Registered read byte |
| mode_exp | output | 1 | 1 in expanded mode |
| base_regs_o | output | 128 | Base bank, register n in bits 8n+7:8n |
| ext_regs_o | output | 128 | Extended bank, register n in bits 8n+7:8n |
| fifo_play_en | output | 1 | Playback FIFO enable |
| fifo_cap_en | output | 1 | Capture FIFO enable |
| duplex_dma_en | output | 1 | Full-duplex DMA enable |
| pd_capture | output | 1 | Capture path power-down |
| pd_playback | output | 1 | Playback path power-down |
| pd_mixer | output | 1 | Mixer path power-down |

## Verification
A mode state that disagrees with bit 6 of register 12 shows on the next cycle. The cause can be a lost transition or an enable taken from the wrong register. The four path controls then switch the wrong way, and extended reads return 0 or stale data. A stale or early-updated index shows on the first data-port read after an index write, because the wrong register comes back. Extended writes leaking through in legacy mode are visible on `ext_regs_o` one edge after the write. The random mix toggles the mode often enough to catch each of these within a few dozen cycles.

// File: rtl/irf_pkg.sv
package irf_pkg;
    typedef enum logic {
        MODE_LEGACY   = 1'b0,
        MODE_EXPANDED = 1'b1
    } mode_state_t;

    localparam int CTRL_BITS = 4;
endpackage

// File: rtl/irf_bank.sv
module irf_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int FLAT_W = DATA_W * DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [FLAT_W-1:0] flat
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q[i] <= '0;
            else if (we && (waddr == AW'(i)))
                cell_q[i] <= wdata;
        end
        assign flat[i*DATA_W +: DATA_W] = cell_q[i];

        // R3: only the addressed slot may change
        assert_slot_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (waddr == AW'(i))) |=> $stable(cell_q[i]));
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/irf_mode_fsm.sv
module irf_mode_fsm
    import irf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 misc_wr,
    input  logic                 misc_mode_bit,
    input  logic [CTRL_BITS-1:0] ctrl_raw,
    output logic                 mode_exp,
    output logic                 fifo_play_en,
    output logic                 fifo_cap_en,
    output logic [CTRL_BITS-1:0] ctrl_eff
);
    mode_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_LEGACY:   if (misc_wr && misc_mode_bit)  state_d = MODE_EXPANDED; // ENTER_EXPANDED
            MODE_EXPANDED: if (misc_wr && !misc_mode_bit) state_d = MODE_LEGACY;   // LEAVE_EXPANDED
            default:       state_d = MODE_LEGACY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_LEGACY;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_exp     = 1'b0;
        fifo_play_en = 1'b1;
        fifo_cap_en  = 1'b1;
        ctrl_eff     = '0;
        unique case (state_q)
            MODE_LEGACY: begin
                mode_exp = 1'b0;
                ctrl_eff = '0;
            end
            MODE_EXPANDED: begin
                mode_exp = 1'b1;
                ctrl_eff = ctrl_raw;
            end
            default: ;
        endcase
    end

    // R9: path controls stay off outside expanded mode
    assert_ctrl_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LEGACY) |-> (ctrl_eff == '0));

    // R4: a mode-bit write is taken on the next edge
    assert_mode_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        misc_wr |=> (mode_exp == $past(misc_mode_bit)));
endmodule

// File: rtl/dual_mode_regfile.sv
module dual_mode_regfile
    import irf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 16,
    parameter int MISC_IDX   = 12,
    parameter int MODE_BIT   = 6,
    parameter int CTRL_IDX   = 0,
    localparam int BANK_AW   = $clog2(BANK_DEPTH),
    localparam int IDX_W     = BANK_AW + 1,
    localparam int FLAT_W    = DATA_W * BANK_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_wr_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_rd_sel,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mode_exp,
    output logic [FLAT_W-1:0] base_regs_o,
    output logic [FLAT_W-1:0] ext_regs_o,
    output logic              fifo_play_en,
    output logic              fifo_cap_en,
    output logic              duplex_dma_en,
    output logic              pd_capture,
    output logic              pd_playback,
    output logic              pd_mixer
);
    localparam logic [BANK_AW-1:0] MISC_SLOT = BANK_AW'(MISC_IDX);

    logic [DATA_W-1:0]    index_q;
    logic [IDX_W-1:0]     dec_idx;
    logic                 in_ext;
    logic [BANK_AW-1:0]   slot;
    logic                 data_wr, base_we, ext_we, misc_wr;
    logic [DATA_W-1:0]    base_rd, ext_rd, rd_mux;
    logic [CTRL_BITS-1:0] ctrl_eff;

    assign dec_idx = index_q[IDX_W-1:0];
    assign in_ext  = dec_idx[IDX_W-1];
    assign slot    = dec_idx[BANK_AW-1:0];

    assign data_wr = host_wr && host_wr_sel;
    assign base_we = data_wr && !in_ext;
    assign ext_we  = data_wr && in_ext && mode_exp;
    assign misc_wr = base_we && (slot == MISC_SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            index_q <= '0;
        else if (host_wr && !host_wr_sel)
            index_q <= host_wdata;
    end

    irf_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_base (
        .clk(clk), .rst_n(rst_n), .we(base_we), .waddr(slot),
        .wdata(host_wdata), .raddr(slot), .rdata(base_rd), .flat(base_regs_o)
    );

    irf_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_ext (
        .clk(clk), .rst_n(rst_n), .we(ext_we), .waddr(slot),
        .wdata(host_wdata), .raddr(slot), .rdata(ext_rd), .flat(ext_regs_o)
    );

    irf_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n),
        .misc_wr(misc_wr), .misc_mode_bit(host_wdata[MODE_BIT]),
        .ctrl_raw(ext_regs_o[CTRL_IDX*DATA_W +: CTRL_BITS]),
        .mode_exp(mode_exp), .fifo_play_en(fifo_play_en),
        .fifo_cap_en(fifo_cap_en), .ctrl_eff(ctrl_eff)
    );

    assign duplex_dma_en = ctrl_eff[0];
    assign pd_capture    = ctrl_eff[1];
    assign pd_playback   = ctrl_eff[2];
    assign pd_mixer      = ctrl_eff[3];

    always_comb begin
        if (!host_rd_sel)      rd_mux = index_q;
        else if (!in_ext)      rd_mux = base_rd;
        else if (mode_exp)     rd_mux = ext_rd;
        else                   rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // R4: mode state agrees with the stored mode bit
    assert_mode_tracks_misc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exp == base_regs_o[MISC_IDX*DATA_W + MODE_BIT]);

    // R5: extended bank frozen in legacy mode
    assert_ext_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_exp |=> $stable(ext_regs_o));

    // R2: index changes only on an index-port write
    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_wr_sel) |=> $stable(index_q));

    // R11: read data holds without a read
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/dual_mode_regfile_tb.sv
module dual_mode_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0, host_wr_sel = 1'b0, host_rd = 1'b0, host_rd_sel = 1'b0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         mode_exp, fifo_play_en, fifo_cap_en;
    logic         duplex_dma_en, pd_capture, pd_playback, pd_mixer;
    logic [127:0] base_regs_o, ext_regs_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] m_base [16];
    logic [7:0] m_ext  [16];
    logic       m_mode;
    logic [7:0] m_idx;
    logic [7:0] m_rd;

    dual_mode_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wr_sel(host_wr_sel), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rd_sel(host_rd_sel), .host_rdata(host_rdata),
        .mode_exp(mode_exp), .base_regs_o(base_regs_o), .ext_regs_o(ext_regs_o),
        .fifo_play_en(fifo_play_en), .fifo_cap_en(fifo_cap_en),
        .duplex_dma_en(duplex_dma_en), .pd_capture(pd_capture),
        .pd_playback(pd_playback), .pd_mixer(pd_mixer)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pack16(input bit ext);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = ext ? m_ext[i] : m_base[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_data_read();
        logic [4:0] i;
        i = m_idx[4:0];
        if (i < 5'd16) return m_base[i[3:0]];
        if (m_mode)    return m_ext[i[3:0]];
        return 8'h00;
    endfunction

    function automatic logic [3:0] exp_ctrl();
        return m_mode ? m_ext[0][3:0] : 4'h0;
    endfunction

    task automatic step(input bit ws, input bit w, input bit rs, input bit r,
                        input logic [7:0] d, input string rtag);
        logic [4:0] i;
        host_wr_sel = ws; host_wr = w; host_rd_sel = rs; host_rd = r; host_wdata = d;
        if (r) m_rd = rs ? exp_data_read() : m_idx;
        if (w) begin
            if (!ws) m_idx = d;
            else begin
                i = m_idx[4:0];
                if (i < 5'd16) begin
                    m_base[i[3:0]] = d;
                    if (i == 5'd12) m_mode = d[6];
                end else if (m_mode) m_ext[i[3:0]] = d;
            end
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk({120'd0, host_rdata}, {120'd0, m_rd}, rtag);
        chk({127'd0, mode_exp}, {127'd0, m_mode}, "R4");
        chk({124'd0, pd_mixer, pd_playback, pd_capture, duplex_dma_en}, {124'd0, exp_ctrl()}, "R9");
        chk({126'd0, fifo_play_en, fifo_cap_en}, 128'd3, "R8");
        chk(ext_regs_o, pack16(1'b1), "R7");
        chk(base_regs_o, pack16(1'b0), "R3");
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        bit ws, w, rs, r;
        logic [7:0] d;
        void'($urandom(32'd4321));
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_ext[i] = '0; end
        m_mode = 0; m_idx = '0; m_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({120'd0, host_rdata}, 128'd0, "R1");
        chk({127'd0, mode_exp}, 128'd0, "R1");
        chk(base_regs_o, 128'd0, "R1");
        chk(ext_regs_o, 128'd0, "R1");
        step(0, 0, 0, 1, 8'h00, "R1");

        // R2 / R3 base access
        step(0, 1, 0, 0, 8'h05, "R11");
        step(0, 0, 0, 1, 8'h00, "R2");
        step(1, 1, 0, 0, 8'hA5, "R11");
        step(0, 0, 1, 1, 8'h00, "R3");

        // R5 legacy: extended hidden
        step(0, 1, 0, 0, 8'h10, "R11");
        step(1, 1, 0, 0, 8'h0F, "R11");
        step(0, 0, 1, 1, 8'h00, "R5");
        chk(ext_regs_o, 128'd0, "R5");

        // R4 enter expanded, R6/R9
        step(0, 1, 0, 0, 8'h0C, "R11");
        step(1, 1, 0, 0, 8'h40, "R11");
        chk({127'd0, mode_exp}, 128'd1, "R4");
        step(0, 1, 0, 0, 8'h10, "R11");
        step(1, 1, 0, 0, 8'h0F, "R11");
        chk({124'd0, pd_mixer, pd_playback, pd_capture, duplex_dma_en}, 128'hF, "R9");
        step(0, 0, 1, 1, 8'h00, "R6");
        chk({120'd0, host_rdata}, 128'h0F, "R6");
        chk({126'd0, fifo_play_en, fifo_cap_en}, 128'd3, "R8");

        // R4 leave, R5/R9, then R7 retention
        step(0, 1, 0, 0, 8'h0C, "R11");
        step(1, 1, 0, 0, 8'h00, "R11");
        chk({127'd0, mode_exp}, 128'd0, "R4");
        chk({124'd0, pd_mixer, pd_playback, pd_capture, duplex_dma_en}, 128'h0, "R9");
        step(0, 1, 0, 0, 8'h10, "R11");
        step(0, 0, 1, 1, 8'h00, "R5");
        chk({120'd0, host_rdata}, 128'h00, "R5");
        step(0, 1, 0, 0, 8'h0C, "R11");
        step(1, 1, 0, 0, 8'h40, "R11");
        step(0, 1, 0, 0, 8'h10, "R11");
        step(0, 0, 1, 1, 8'h00, "R7");
        chk({120'd0, host_rdata}, 128'h0F, "R7");

        // R10: index write and data read in one cycle; high index bits ignored
        step(0, 1, 1, 1, 8'hE5, "R10");
        chk({120'd0, host_rdata}, 128'h0F, "R10");
        step(0, 0, 1, 1, 8'h00, "R10");
        chk({120'd0, host_rdata}, 128'hA5, "R10");
        step(0, 0, 0, 1, 8'h00, "R2");
        chk({120'd0, host_rdata}, 128'hE5, "R2");
        step(0, 0, 0, 0, 8'h00, "R11");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            ws = $urandom_range(0, 1);
            w  = $urandom_range(0, 1);
            rs = $urandom_range(0, 1);
            r  = $urandom_range(0, 1);
            d  = 8'($urandom);
            if (w && !ws && $urandom_range(0, 3) == 0) d = {d[7:5], 5'd12};
            if (!r)                             tag = "R11";
            else if (!rs)                       tag = "R2";
            else if (w && !ws)                  tag = "R10";
            else if (m_idx[4] == 1'b0)          tag = "R3";
            else if (m_mode)                    tag = "R6";
            else                                tag = "R5";
            step(ws, w, rs, r, d, tag);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule